// File: doc/BRIEF.md
# Dual-Line Parallel Word Search

The block looks for one word of up to five lowercase characters in two lines of ASCII text at the same time. Both lines sit in a shared synchronous memory that has two read ports. A single-cycle start pulse loads the search key and one start address for each line. From then on, each line is scanned one character per clock. Each line has its own match engine, which builds the current text word in a five-byte register and compares it with the key whenever a space or the end-of-text code arrives. One controller holds, for each line, an address counter, a read enable and a character-slot counter.

The result is a pair of sticky flags. The hit flag rises as soon as either line produces a whole-word match, and that match also halts reading on both lines. The miss flag rises only once both lines have reached their end-of-text code without a match. A new start pulse clears both flags and starts a fresh search, abandoning any search in progress.

The memory side is a plain fixed-latency read port rather than a valid/ready stream. Every read issued with an enable low is answered with data exactly one clock later, and the memory cannot stall. Back-pressure therefore does not exist: the block consumes one byte per line per cycle while it is searching.

Top module: `dual_word_search`

## Requirements
- R1: The key and both start addresses are sampled only on the rising edge where `start_i` is high. Later changes to `word_i`, `base_a_i` or `base_b_i` have no effect on the search in progress.
- R2: Text is one 8-bit character per address. 0x20 separates words and 0x03 ends a line. The key holds its first character in bits 39:32, its second in bits 31:24, and so on, and unused low bytes are zero.
- R3: Call the start-sampling edge edge 0, and let t be the offset from the start address of the space or end-of-text code that ends the first matching word on a line. `hit_o` rises after edge t+2.
- R4: Only a whole word equal to the key matches. A word that is a prefix of the key does not match. A word longer than five characters never matches, even when its first five characters equal the key.
- R5: When neither line matches, `miss_o` rises after edge m+2, where m is the larger of the two end-of-text offsets. It stays low until then.
- R6: A match on either line sets `hit_o`, even if the other line has already ended without a match. `hit_o` and `miss_o` are never high together.
- R7: Both flags are low after the start-sampling edge. Once set, a flag holds its value until the next start pulse.
- R8: Each read enable is active low (0 = read). While a line is searching it issues one read per cycle, at addresses base, base+1, and so on, starting in the cycle after edge 0. The address wraps modulo 1024.
- R9: From the edge that sets `hit_o`, both read enables are high. From the edge that records a line's end-of-text code, that line's enable is high. Either way the enables stay high until the next start pulse.
- R10: A start pulse during a search abandons that search. The flags then report only the new key, with the timing of R3 and R5 counted from the new pulse.
- R11: During reset both flags are 0 and both read enables are 1.
- R12: An empty word never matches a nonzero key. Empty words come from consecutive spaces, a leading space, or a line that is only the end-of-text code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that starts a search |
| word_i | input | 40 | Search key, left-aligned, zero-padded |
| base_a_i | input | 10 | Start address of line A |
| base_b_i | input | 10 | Start address of line B |
| rdata_a_i | input | 8 | Read data for line A, one cycle after the read |
| rdata_b_i | input | 8 | Read data for line B, one cycle after the read |
| raddr_a_o | output | 10 | Read address for line A |
| raddr_b_o | output | 10 | Read address for line B |
| rd_n_a_o | output | 1 | Read enable for line A, active low |
| rd_n_b_o | output | 1 | Read enable for line B, active low |
| hit_o | output | 1 | Key found on at least one line |
| miss_o | output | 1 | Both lines ended without a match |

## Verification
Every result falls due at a fixed edge. The read address appears in the cycle after the sampling edge, and a flag appears two edges after the offset of the character that ends the search. The bench runs its own tokenizer over the memory image it wrote to find those offsets. It samples on falling edges, checking that both flags are still low one edge before the due edge and hold the expected values at the due edge. The read enables are checked at that same sample. Restart and stickiness checks count edges from the start pulse that applies.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int CHAR_W = 8;
  localparam int LANES  = 2;
  localparam logic [CHAR_W-1:0] SPACE_CH = 8'h20;
  localparam logic [CHAR_W-1:0] ETX_CH   = 8'h03;
endpackage

// File: rtl/ws_controller.sv
module ws_controller
  import ws_pkg::*;
#(
  parameter int AW    = 10,
  parameter int NCHAR = 5,
  parameter int SW    = $clog2(NCHAR + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [LANES-1:0][AW-1:0]  base_i,
  input  logic [LANES-1:0]          sep_i,
  input  logic [LANES-1:0]          etx_i,
  input  logic [LANES-1:0]          match_i,
  output logic [LANES-1:0][AW-1:0]  addr_o,
  output logic [LANES-1:0]          rd_n_o,
  output logic [LANES-1:0]          dv_o,
  output logic [LANES-1:0][SW-1:0]  slot_o
);

  logic halt_all;
  assign halt_all = |match_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic          active_q;
    logic          dv_q;
    logic [AW-1:0] addr_q;
    logic [SW-1:0] slot_q;
    logic          stop_now;

    assign stop_now = halt_all | etx_i[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        active_q <= 1'b0;
        dv_q     <= 1'b0;
        addr_q   <= '0;
        slot_q   <= '0;
      end else if (start_i) begin
        active_q <= 1'b1;
        dv_q     <= 1'b0;
        addr_q   <= base_i[g];
        slot_q   <= '0;
      end else begin
        if (active_q) addr_q <= addr_q + 1'b1;
        dv_q <= active_q & ~stop_now;
        if (stop_now) active_q <= 1'b0;
        if (dv_q) begin
          if (sep_i[g])                slot_q <= '0;
          else if (slot_q < SW'(NCHAR)) slot_q <= slot_q + 1'b1;
        end
      end
    end

    assign addr_o[g] = addr_q;
    assign rd_n_o[g] = ~active_q;
    assign dv_o[g]   = dv_q;
    assign slot_o[g] = slot_q;

    // R8: a read this cycle means the next address is one higher
    a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n_o[g] && !start_i) |=> (addr_o[g] == $past(addr_o[g]) + 1'b1));

    // R12: a separator sends the next word back to slot 0
    a_r12_slot_rewind: assert property (@(posedge clk) disable iff (!rst_n)
      (sep_i[g] && !start_i) |=> (slot_o[g] == '0));

    // R9: end of text closes this lane's reads
    a_r9_etx_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (etx_i[g] && !start_i) |=> rd_n_o[g]);
  end

  // R9: a match on any lane closes every lane
  a_r9_match_halts_all: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_all && !start_i) |=> (&rd_n_o));

endmodule

// File: rtl/ws_match_engine.sv
module ws_match_engine
  import ws_pkg::*;
#(
  parameter int NCHAR = 5,
  parameter int SW    = $clog2(NCHAR + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [NCHAR*CHAR_W-1:0] key_i,
  input  logic                    dv_i,
  input  logic [SW-1:0]           slot_i,
  input  logic [CHAR_W-1:0]       rdata_i,
  output logic                    sep_o,
  output logic                    etx_o,
  output logic                    match_o,
  output logic                    found_o,
  output logic                    nf_o
);

  localparam int KW = NCHAR * CHAR_W;

  logic [KW-1:0] key_q;
  logic [KW-1:0] cand_q;
  logic          long_q;
  logic          found_q;
  logic          nf_q;

  assign etx_o   = dv_i & (rdata_i == ETX_CH);
  assign sep_o   = dv_i & ((rdata_i == SPACE_CH) | (rdata_i == ETX_CH));
  assign match_o = sep_o & ~long_q & (cand_q == key_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      cand_q  <= '0;
      long_q  <= 1'b0;
      found_q <= 1'b0;
      nf_q    <= 1'b0;
    end else if (start_i) begin
      key_q   <= key_i;
      cand_q  <= '0;
      long_q  <= 1'b0;
      found_q <= 1'b0;
      nf_q    <= 1'b0;
    end else if (dv_i) begin
      if (sep_o) begin
        cand_q <= '0;
        long_q <= 1'b0;
        if (match_o)    found_q <= 1'b1;
        else if (etx_o) nf_q    <= 1'b1;
      end else if (slot_i >= SW'(NCHAR)) begin
        long_q <= 1'b1;
      end else begin
        for (int i = 0; i < NCHAR; i++) begin
          if (slot_i == SW'(i)) cand_q[(NCHAR-1-i)*CHAR_W +: CHAR_W] <= rdata_i;
        end
      end
    end
  end

  assign found_o = found_q;
  assign nf_o    = nf_q;

  // R7: flags are sticky between start pulses
  a_r7_found_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (found_o && !start_i) |=> found_o);
  a_r7_nf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (nf_o && !start_i) |=> nf_o);

  // R6: one lane never reports both outcomes
  a_r6_lane_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(found_o && nf_o));

endmodule

// File: rtl/dual_word_search.sv
module dual_word_search
  import ws_pkg::*;
#(
  parameter int AW    = 10,
  parameter int NCHAR = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [NCHAR*CHAR_W-1:0]  word_i,
  input  logic [AW-1:0]            base_a_i,
  input  logic [AW-1:0]            base_b_i,
  input  logic [CHAR_W-1:0]        rdata_a_i,
  input  logic [CHAR_W-1:0]        rdata_b_i,
  output logic [AW-1:0]            raddr_a_o,
  output logic [AW-1:0]            raddr_b_o,
  output logic                     rd_n_a_o,
  output logic                     rd_n_b_o,
  output logic                     hit_o,
  output logic                     miss_o
);

  localparam int SW = $clog2(NCHAR + 1);

  logic [LANES-1:0][AW-1:0]     base;
  logic [LANES-1:0][AW-1:0]     addr;
  logic [LANES-1:0][CHAR_W-1:0] rdata;
  logic [LANES-1:0][SW-1:0]     slot;
  logic [LANES-1:0]             rd_n, dv, sep, etx, match, found, nf;

  assign base  = {base_b_i, base_a_i};
  assign rdata = {rdata_b_i, rdata_a_i};

  ws_controller #(.AW(AW), .NCHAR(NCHAR), .SW(SW)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .base_i  (base),
    .sep_i   (sep),
    .etx_i   (etx),
    .match_i (match),
    .addr_o  (addr),
    .rd_n_o  (rd_n),
    .dv_o    (dv),
    .slot_o  (slot)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_eng
    ws_match_engine #(.NCHAR(NCHAR), .SW(SW)) eng_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .key_i   (word_i),
      .dv_i    (dv[g]),
      .slot_i  (slot[g]),
      .rdata_i (rdata[g]),
      .sep_o   (sep[g]),
      .etx_o   (etx[g]),
      .match_o (match[g]),
      .found_o (found[g]),
      .nf_o    (nf[g])
    );
  end

  assign raddr_a_o = addr[0];
  assign raddr_b_o = addr[1];
  assign rd_n_a_o  = rd_n[0];
  assign rd_n_b_o  = rd_n[1];
  assign hit_o     = |found;
  assign miss_o    = &nf;

  // R7: a start pulse clears both results on its edge
  a_r7_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!hit_o && !miss_o));

  // R6: combined outcomes are exclusive
  a_r6_hit_miss_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_o && miss_o));

  // R9: once found, no lane keeps reading
  a_r9_quiet_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !start_i) |-> (rd_n_a_o && rd_n_b_o));

endmodule

// File: tb/dual_word_search_tb_top.sv
module dual_word_search_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [39:0] word_i = '0;
  logic [9:0]  base_a_i = '0, base_b_i = '0;
  logic [7:0]  rdata_a_i = '0, rdata_b_i = '0;
  logic [9:0]  raddr_a_o, raddr_b_o;
  logic        rd_n_a_o, rd_n_b_o, hit_o, miss_o;

  logic [7:0]  mem [1024];
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  dual_word_search dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
    .base_a_i(base_a_i), .base_b_i(base_b_i),
    .rdata_a_i(rdata_a_i), .rdata_b_i(rdata_b_i),
    .raddr_a_o(raddr_a_o), .raddr_b_o(raddr_b_o),
    .rd_n_a_o(rd_n_a_o), .rd_n_b_o(rd_n_b_o),
    .hit_o(hit_o), .miss_o(miss_o)
  );

  // Two-port synchronous memory, one cycle of read latency
  always_ff @(posedge clk) begin
    if (!rd_n_a_o) rdata_a_i <= mem[raddr_a_o];
    if (!rd_n_b_o) rdata_b_i <= mem[raddr_b_o];
  end

  // {key, base A, base B}
  localparam logic [59:0] VEC [10] = '{
    {40'h7265640000, 10'd0,   10'd100},  // red
    {40'h6d61746368, 10'd0,   10'd100},  // match
    {40'h7768697465, 10'd0,   10'd100},  // white
    {40'h6162636465, 10'd200, 10'd300},  // abcde vs overlong
    {40'h68656c6c6f, 10'd400, 10'd300},  // hello after blanks
    {40'h6d61740000, 10'd100, 10'd0},    // mat, prefix of match
    {40'h6162000000, 10'd300, 10'd400},  // ab
    {40'h7468650000, 10'd0,   10'd0},    // the
    {40'h7361740000, 10'd100, 10'd100},  // sat, absent
    {40'h6d61000000, 10'd100, 10'd400}   // ma, prefix only
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put_line(input int at, input string s);
    for (int i = 0; i < s.len(); i++) mem[10'(at + i)] = s[i];
    mem[10'(at + s.len())] = 8'h03;
  endtask

  // Independent tokenizer: finds the terminal offset for one line
  task automatic ref_lane(input logic [39:0] key, input logic [9:0] base,
                          output bit fnd, output int off);
    logic [39:0] acc;
    int n;
    acc = '0; n = 0; fnd = 0; off = 0;
    for (int i = 0; i < 1024; i++) begin
      logic [7:0] c;
      c = mem[10'(base + i)];
      if (c == 8'h20 || c == 8'h03) begin
        if (n <= 5 && acc == key) begin fnd = 1; off = i; return; end
        if (c == 8'h03) begin off = i; return; end
        acc = '0; n = 0;
      end else begin
        if (n < 5) acc[39 - 8*n -: 8] = c;
        n++;
      end
    end
  endtask

  task automatic pulse_start(input logic [39:0] k, input logic [9:0] a, input logic [9:0] b);
    @(negedge clk);
    word_i = k; base_a_i = a; base_b_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Waits from the sample after edge 0 and checks the due edge
  task automatic await_result(input logic [39:0] k, input logic [9:0] a,
                              input logic [9:0] b, input string req);
    bit fa, fb; int oa, ob, due; bit eh, em;
    ref_lane(k, a, fa, oa);
    ref_lane(k, b, fb, ob);
    if (fa || fb) begin
      eh = 1; em = 0;
      due = (fa && fb) ? ((oa < ob) ? oa : ob) : (fa ? oa : ob);
    end else begin
      eh = 0; em = 1;
      due = (oa > ob) ? oa : ob;
    end
    due += 2;
    repeat (due - 1) @(negedge clk);
    check(!hit_o && !miss_o, req, "flags before due edge", {hit_o, miss_o}, 2'b00);
    @(negedge clk);
    check(hit_o == eh, req, "hit at due edge", hit_o, eh);
    check(miss_o == em, req, "miss at due edge", miss_o, em);
    check(rd_n_a_o && rd_n_b_o, "R9", "enables after result", {rd_n_a_o, rd_n_b_o}, 2'b11);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    put_line(0,   "the red cat sat on the mat");
    put_line(100, "it waited for the match");
    put_line(200, "abcdefg xyz");
    put_line(300, "");
    put_line(400, "  ab  hello");
    put_line(500, "abcdefgh abcde");

    // R11: reset state
    repeat (3) @(negedge clk);
    check(!hit_o && !miss_o, "R11", "flags in reset", {hit_o, miss_o}, 2'b00);
    check(rd_n_a_o && rd_n_b_o, "R11", "enables in reset", {rd_n_a_o, rd_n_b_o}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: R2, R3, R5 across patterns
    for (int v = 0; v < 10; v++) begin
      pulse_start(VEC[v][59:20], VEC[v][19:10], VEC[v][9:0]);
      await_result(VEC[v][59:20], VEC[v][19:10], VEC[v][9:0], "R2/R3/R5");
    end

    // R4: overlong word with matching head, real match later
    pulse_start(40'h6162636465, 10'd500, 10'd300);
    await_result(40'h6162636465, 10'd500, 10'd300, "R4");

    // R6: lane A ends at once, lane B finds later
    pulse_start(40'h78797a0000, 10'd300, 10'd200);
    await_result(40'h78797a0000, 10'd300, 10'd200, "R6");

    // R12: empty line on both lanes gives miss at edge 2
    pulse_start(40'h68656c6c6f, 10'd300, 10'd300);
    await_result(40'h68656c6c6f, 10'd300, 10'd300, "R12");

    // R8: address sequence and enables, then R10 restart mid-search
    pulse_start(40'h7768697465, 10'd0, 10'd100);
    check(raddr_a_o == 10'd0 && !rd_n_a_o, "R8", "lane A first read", raddr_a_o, 0);
    check(raddr_b_o == 10'd100 && !rd_n_b_o, "R8", "lane B first read", raddr_b_o, 100);
    @(negedge clk);
    check(raddr_a_o == 10'd1, "R8", "lane A second read", raddr_a_o, 1);
    check(raddr_b_o == 10'd101, "R8", "lane B second read", raddr_b_o, 101);
    repeat (2) @(negedge clk);
    pulse_start(40'h6361740000, 10'd0, 10'd100);
    await_result(40'h6361740000, 10'd0, 10'd100, "R10");

    // R1: inputs changed right after sampling are ignored
    pulse_start(40'h7265640000, 10'd0, 10'd100);
    word_i = 40'h7768697465; base_a_i = 10'd400; base_b_i = 10'd300;
    await_result(40'h7265640000, 10'd0, 10'd100, "R1");

    // R7: sticky hit, then cleared by the next start
    repeat (5) @(negedge clk);
    check(hit_o && !miss_o, "R7", "hit held", {hit_o, miss_o}, 2'b10);
    pulse_start(40'h7768697465, 10'd0, 10'd100);
    check(!hit_o && !miss_o, "R7", "cleared after start", {hit_o, miss_o}, 2'b00);
    await_result(40'h7768697465, 10'd0, 10'd100, "R7");
    repeat (6) @(negedge clk);
    check(miss_o && !hit_o, "R7", "miss held", {hit_o, miss_o}, 2'b01);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule